// File: doc/BRIEF.md
# Polling Card Emulator Responder

This block lets a contactless reader interface act as a simple card. It sits between a frame receiver and a frame transmitter. When the receiver reports a complete frame with a good checksum, the block reads three header bytes through the receiver's byte read port: the length byte at offset 2, the command byte at offset 3 and the request code at offset 6. From these it decides whether the frame is one of the commands it answers.

For a recognised command the block builds one of three fixed replies. It inserts the 8-byte card identifier, which it captures when the decision is made. It then computes the reply checksum one byte per cycle and fires a single start pulse to the transmitter at a fixed tick distance after the request frame completed. The transmitter fetches reply bytes by address through a combinational read port.

Frames with a bad checksum or an unknown command are dropped. In both cases the receiver is told to clear. A frame that arrives while a reply is pending or being sent is dropped without any effect.

Top module: `polling_responder`

## Requirements
- R1: When `frameDone` is high with `crcOk` low while the block is listening, `rxClear` pulses in that same cycle and no `txStart` follows.
- R2: A frame with length byte 6, command 0x00 and request code 0 is answered with a 22-byte reply (`txLen` = 0x16). The reply bytes, by index, are: 0 = B2, 1 = 4D, 2 = 0x12, 3 = 0x01, 4..11 = identifier with `cardId[63:56]` at index 4, and 12..19 = 00 F1 00 00 00 01 43 00.
- R3: The same frame with request code 1 is answered with a 24-byte reply (`txLen` = 0x18). Byte 2 is 0x14 and byte 3 is 0x01. Bytes 4..19 follow R2, and bytes 20 and 21 are 88 and B4.
- R4: A frame whose length byte exceeds 5 and whose command is 0x06 is answered with a 33-byte reply (`txLen` = 0x21). Byte 2 is 0x1D, byte 3 is 0x07 and bytes 4..11 are the identifier. Bytes 12..30 are 00 00 01 10 04 01 00 0D 00 00 00 00 00 01 00 00 00 00 23.
- R5: With L the reply's length byte, bytes L+2 and L+3 hold the high and low halves of a CRC-16. The CRC uses polynomial 0x1021, initial value 0, and is computed MSB first over reply bytes 2 to L+1 with the identifier already inserted. Reads at an index past the reply return 0.
- R6: `txStart` is high for exactly one cycle. That cycle is the first in which `tickNow` has reached T+512, where T is the `tickNow` value in the cycle `frameDone` was accepted. The comparison is wrap-safe modulo 2^32, and `txStartTime` shows T+512.
- R7: A good-CRC frame matching none of R2 to R4 is ignored. This covers a poll request code other than 0 or 1, a command 0x00 frame with a length byte other than 6, a command 0x06 frame with a length byte of 5 or less, and any other command. For such a frame `rxClear` pulses once within a few cycles and no `txStart` occurs.
- R8: A `frameDone` that arrives while a reply is pending or being sent leaves `txStartTime`, `txLen` and the reply untouched, and causes no extra `txStart`.
- R9: A `txDone` pulse after `txStart` pulses `rxClear` in the same cycle and returns the block to listening, so the next request is answered again.
- R10: After reset `txStart` and `rxClear` are low and `txLen` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| frameDone | input | 1 | One-cycle pulse: the receiver holds a complete frame |
| crcOk | input | 1 | Checksum status of the frame, valid with `frameDone` |
| rxRdAddr | output | 8 | Byte index into the received frame |
| rxRdData | input | 8 | Received frame byte, valid one cycle after `rxRdAddr` |
| rxClear | output | 1 | One-cycle pulse telling the receiver to discard its frame |
| tickNow | input | 32 | Free-running tick counter |
| cardId | input | 64 | Card identifier, most significant byte sent first |
| txRdAddr | input | 8 | Byte index requested by the transmitter |
| txByte | output | 8 | Reply byte at `txRdAddr` (combinational) |
| txLen | output | 8 | Total reply length in bytes, including sync and CRC |
| txStartTime | output | 32 | Tick at which the reply is launched |
| txStart | output | 1 | One-cycle pulse: start sending the reply |
| txDone | input | 1 | One-cycle pulse from the transmitter: reply sent |

## Verification
A wrong decode latch or reply-kind register shows at the ports either as a missing or extra `txStart`, or as a `txLen` and byte image that do not match the request. Both are visible within about 520 cycles of `frameDone`. A stale identifier or checksum register corrupts bytes 4..11 or the last two reply bytes, and a read sweep at the start pulse exposes this. A control state that fails to return to listening or to ignore traffic shows up in one of two ways: the `rxClear` pulse is missing right after a rejected frame or after `txDone`, or a second start pulse appears after a request sent during a busy period.

// File: rtl/resp_pkg.sv
package resp_pkg;

  typedef enum logic [1:0] {KIND_NONE, KIND_POLL0, KIND_POLL1, KIND_READ} kind_t;

  typedef enum logic [2:0] {S_IDLE, S_FETCH, S_DECIDE, S_CRC, S_WAIT, S_SEND} state_t;

  // strobes from control to datapath
  typedef struct packed {
    logic       latchTick;
    logic       fetch;
    logic [1:0] fetchIdx;
    logic       commit;
    logic       crcStep;
  } dpStrobe_t;

  function automatic logic [7:0] lenOf(input kind_t k);
    case (k)
      KIND_POLL0: return 8'h12;
      KIND_POLL1: return 8'h14;
      KIND_READ:  return 8'h1D;
      default:    return 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] cmdOf(input kind_t k);
    case (k)
      KIND_POLL0, KIND_POLL1: return 8'h01;
      KIND_READ:              return 8'h07;
      default:                return 8'h00;
    endcase
  endfunction

  // constant payload bytes after the identifier
  function automatic logic [7:0] fixedOf(input kind_t k, input int ix);
    logic [7:0] b;
    b = 8'h00;
    if (k == KIND_POLL0 || k == KIND_POLL1) begin
      case (ix)
        13: b = 8'hF1;
        17: b = 8'h01;
        18: b = 8'h43;
        20: b = (k == KIND_POLL1) ? 8'h88 : 8'h00;
        21: b = (k == KIND_POLL1) ? 8'hB4 : 8'h00;
        default: b = 8'h00;
      endcase
    end else if (k == KIND_READ) begin
      case (ix)
        14, 17, 25: b = 8'h01;
        15: b = 8'h10;
        16: b = 8'h04;
        19: b = 8'h0D;
        30: b = 8'h23;
        default: b = 8'h00;
      endcase
    end
    return b;
  endfunction

  function automatic logic [15:0] crcByte(input logic [15:0] c, input logic [7:0] d);
    logic [15:0] r;
    logic fb;
    r = c;
    for (int i = 7; i >= 0; i--) begin
      fb = r[15] ^ d[i];
      r = {r[14:0], 1'b0};
      if (fb) r = r ^ 16'h1021;
    end
    return r;
  endfunction

endpackage

// File: rtl/resp_datapath.sv
module resp_datapath
  import resp_pkg::*;
#(
  parameter int TICK_W      = 32,
  parameter int ADDR_W      = 8,
  parameter int REPLY_DELAY = 512
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         st,
  input  logic [TICK_W-1:0] tickNow,
  input  logic [63:0]       cardId,
  output logic [ADDR_W-1:0] rxRdAddr,
  input  logic [7:0]        rxRdData,
  input  logic [ADDR_W-1:0] txRdAddr,
  output logic [7:0]        txByte,
  output logic [7:0]        txLen,
  output logic [TICK_W-1:0] txStartTime,
  output kind_t             decKind,
  output logic              crcDone,
  output logic              due
);
  localparam int ID_OFS = 4;
  localparam int ID_END = ID_OFS + 8;

  logic [TICK_W-1:0] tickReg, startReg, diff;
  logic [7:0]        lenReg, cmdReg, reqReg;
  logic              fetchQ;
  logic [1:0]        idxQ;
  kind_t             kindReg;
  logic [63:0]       idReg;
  logic [15:0]       crcReg;
  logic [ADDR_W-1:0] crcIdx;

  function automatic logic [7:0] respByte(input kind_t k, input logic [ADDR_W-1:0] idx,
                                          input logic [63:0] id, input logic [15:0] crc);
    int ix;
    int l;
    logic [5:0] base;
    ix = int'(idx);
    l  = int'(lenOf(k));
    base = 6'((ID_END - 1 - ix) * 8);
    if (ix == 0)                       return 8'hB2;
    else if (ix == 1)                  return 8'h4D;
    else if (ix == 2)                  return lenOf(k);
    else if (ix == 3)                  return cmdOf(k);
    else if (ix >= ID_OFS && ix < ID_END) return id[base +: 8];
    else if (ix < l + 2)               return fixedOf(k, ix);
    else if (ix == l + 2)              return crc[15:8];
    else if (ix == l + 3)              return crc[7:0];
    else                               return 8'h00;
  endfunction

  always_comb begin
    rxRdAddr = '0;
    if (st.fetch) begin
      case (st.fetchIdx)
        2'd0:    rxRdAddr = ADDR_W'(2);
        2'd1:    rxRdAddr = ADDR_W'(3);
        default: rxRdAddr = ADDR_W'(6);
      endcase
    end
  end

  always_comb begin
    decKind = KIND_NONE;
    if (lenReg == 8'd6 && cmdReg == 8'h00 && reqReg == 8'h00)      decKind = KIND_POLL0;
    else if (lenReg == 8'd6 && cmdReg == 8'h00 && reqReg == 8'h01) decKind = KIND_POLL1;
    else if (lenReg > 8'd5 && cmdReg == 8'h06)                     decKind = KIND_READ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tickReg  <= '0;
      startReg <= '0;
      lenReg   <= '0;
      cmdReg   <= '0;
      reqReg   <= '0;
      fetchQ   <= 1'b0;
      idxQ     <= '0;
      kindReg  <= KIND_NONE;
      idReg    <= '0;
      crcReg   <= '0;
      crcIdx   <= '0;
    end else begin
      fetchQ <= st.fetch;
      idxQ   <= st.fetchIdx;
      if (st.latchTick) tickReg <= tickNow;
      if (fetchQ) begin
        case (idxQ)
          2'd0:    lenReg <= rxRdData;
          2'd1:    cmdReg <= rxRdData;
          default: reqReg <= rxRdData;
        endcase
      end
      if (st.commit) begin
        kindReg  <= decKind;
        idReg    <= cardId;
        startReg <= tickReg + TICK_W'(REPLY_DELAY);
        crcReg   <= '0;
        crcIdx   <= ADDR_W'(2);
      end else if (st.crcStep) begin
        crcReg <= crcByte(crcReg, respByte(kindReg, crcIdx, idReg, crcReg));
        crcIdx <= crcIdx + 1'b1;
      end
    end
  end

  assign crcDone     = (crcIdx == ADDR_W'(lenOf(kindReg)) + ADDR_W'(2));
  assign diff        = tickNow - startReg;
  assign due         = !diff[TICK_W-1];
  assign txByte      = respByte(kindReg, txRdAddr, idReg, crcReg);
  assign txLen       = (kindReg == KIND_NONE) ? 8'h00 : lenOf(kindReg) + 8'd4;
  assign txStartTime = startReg;

endmodule

// File: rtl/resp_control.sv
module resp_control
  import resp_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      frameDone,
  input  logic      crcOk,
  input  logic      txDone,
  input  kind_t     decKind,
  input  logic      crcDone,
  input  logic      due,
  output dpStrobe_t st,
  output logic      rxClear,
  output logic      txStart,
  output logic      busy
);
  state_t     state, nextState;
  logic [1:0] fetchCnt;

  always_comb begin
    st        = '0;
    rxClear   = 1'b0;
    txStart   = 1'b0;
    nextState = state;
    case (state)
      S_IDLE: begin
        if (frameDone) begin
          if (crcOk) begin
            st.latchTick = 1'b1;
            nextState    = S_FETCH;
          end else begin
            rxClear = 1'b1;
          end
        end
      end
      S_FETCH: begin
        st.fetch    = (fetchCnt != 2'd3);
        st.fetchIdx = fetchCnt;
        if (fetchCnt == 2'd3) nextState = S_DECIDE;
      end
      S_DECIDE: begin
        if (decKind == KIND_NONE) begin
          rxClear   = 1'b1;
          nextState = S_IDLE;
        end else begin
          st.commit = 1'b1;
          nextState = S_CRC;
        end
      end
      S_CRC: begin
        if (crcDone) nextState = S_WAIT;
        else         st.crcStep = 1'b1;
      end
      S_WAIT: begin
        if (due) begin
          txStart   = 1'b1;
          nextState = S_SEND;
        end
      end
      S_SEND: begin
        if (txDone) begin
          rxClear   = 1'b1;
          nextState = S_IDLE;
        end
      end
      default: nextState = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= S_IDLE;
      fetchCnt <= '0;
    end else begin
      state    <= nextState;
      fetchCnt <= (state == S_FETCH) ? fetchCnt + 2'd1 : 2'd0;
    end
  end

  assign busy = (state != S_IDLE);

endmodule

// File: rtl/polling_responder.sv
module polling_responder
  import resp_pkg::*;
#(
  parameter int TICK_W      = 32,
  parameter int ADDR_W      = 8,
  parameter int REPLY_DELAY = 512
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              frameDone,
  input  logic              crcOk,
  output logic [ADDR_W-1:0] rxRdAddr,
  input  logic [7:0]        rxRdData,
  output logic              rxClear,
  input  logic [TICK_W-1:0] tickNow,
  input  logic [63:0]       cardId,
  input  logic [ADDR_W-1:0] txRdAddr,
  output logic [7:0]        txByte,
  output logic [7:0]        txLen,
  output logic [TICK_W-1:0] txStartTime,
  output logic              txStart,
  input  logic              txDone
);
  dpStrobe_t st;
  kind_t     decKind;
  logic      crcDone, due, busy;

  resp_control i_ctrl (
    .clk(clk), .rstN(rstN), .frameDone(frameDone), .crcOk(crcOk), .txDone(txDone),
    .decKind(decKind), .crcDone(crcDone), .due(due), .st(st),
    .rxClear(rxClear), .txStart(txStart), .busy(busy)
  );

  resp_datapath #(.TICK_W(TICK_W), .ADDR_W(ADDR_W), .REPLY_DELAY(REPLY_DELAY)) i_dp (
    .clk(clk), .rstN(rstN), .st(st), .tickNow(tickNow), .cardId(cardId),
    .rxRdAddr(rxRdAddr), .rxRdData(rxRdData), .txRdAddr(txRdAddr), .txByte(txByte),
    .txLen(txLen), .txStartTime(txStartTime), .decKind(decKind),
    .crcDone(crcDone), .due(due)
  );

endmodule

// File: rtl/responder_checker.sv
module responder_checker #(
  parameter int TICK_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              frameDone,
  input logic              crcOk,
  input logic              busy,
  input logic              rxClear,
  input logic              txStart,
  input logic              txDone,
  input logic [7:0]        txLen,
  input logic [TICK_W-1:0] txStartTime
);
  // R1: bad checksum while listening clears at once and stays listening
  p_bad_crc_clear_r1: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && frameDone && !crcOk) |-> (rxClear && !txStart));
  p_bad_crc_idle_r1: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && frameDone && !crcOk) |=> !busy);
  // R6: start is a single-cycle pulse
  p_one_start_r6: assert property (@(posedge clk) disable iff (!rstN)
    txStart |=> !txStart);
  // R6: launch time holds from start pulse into sending
  p_time_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    txStart |=> $stable(txStartTime));
  // R4: any start carries one of the three reply lengths (also R2, R3)
  p_start_len_r4: assert property (@(posedge clk) disable iff (!rstN)
    txStart |-> (txLen == 8'h16 || txLen == 8'h18 || txLen == 8'h21));
  // R8: a frame during a busy period never returns the block to listening
  p_drop_r8: assert property (@(posedge clk) disable iff (!rstN)
    (busy && frameDone && !txDone && !txStart) |=> busy);
  // R9: clear and start never coincide
  p_clear_not_start_r9: assert property (@(posedge clk) disable iff (!rstN)
    rxClear |-> !txStart);
  // R10: nothing pulses while in reset
  always_comb begin
    if (!rstN) p_reset_quiet_r10: assert (!txStart && !rxClear);
  end
endmodule

bind polling_responder responder_checker #(.TICK_W(TICK_W)) i_chk (
  .clk(clk), .rstN(rstN), .frameDone(frameDone), .crcOk(crcOk), .busy(busy),
  .rxClear(rxClear), .txStart(txStart), .txDone(txDone), .txLen(txLen),
  .txStartTime(txStartTime)
);

// File: tb/test_polling_responder.sv
`timescale 1ns/1ps
module test_polling_responder;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        frameDone = 1'b0, crcOk = 1'b0, txDone = 1'b0;
  logic [7:0]  rxRdAddr, rxRdData = 8'h00, txRdAddr = 8'h00, txByte, txLen;
  logic        rxClear, txStart;
  logic [31:0] tickNow = 32'hFFFF_FE80, txStartTime;
  logic [63:0] cardId = 64'h0;

  logic [7:0]  rxMem [0:15];
  logic [7:0]  expFrame [0:40];
  int          expLen;
  int          checks = 0, errors = 0;
  int          startCnt = 0, clrCnt = 0;
  logic [31:0] lastStartTick = 0;

  always #2 clk = ~clk;

  polling_responder i_polling_responder (
    .clk(clk), .rstN(rstN), .frameDone(frameDone), .crcOk(crcOk),
    .rxRdAddr(rxRdAddr), .rxRdData(rxRdData), .rxClear(rxClear),
    .tickNow(tickNow), .cardId(cardId), .txRdAddr(txRdAddr), .txByte(txByte),
    .txLen(txLen), .txStartTime(txStartTime), .txStart(txStart), .txDone(txDone)
  );

  initial forever begin @(posedge clk); tickNow <= tickNow + 1; end
  initial forever begin @(posedge clk); rxRdData <= rxMem[rxRdAddr[3:0]]; end
  initial forever begin
    @(negedge clk); #1;
    if (txStart) begin startCnt++; lastStartTick = tickNow; end
    if (rxClear) clrCnt++;
  end

  task automatic check(input logic ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] refCrc(input int l);
    logic [15:0] c = 16'h0;
    for (int i = 2; i < l + 2; i++)
      for (int b = 7; b >= 0; b--) begin
        logic fb = c[15] ^ expFrame[i][b];
        c = {c[14:0], 1'b0};
        if (fb) c ^= 16'h1021;
      end
    return c;
  endfunction

  task automatic buildExp(input int kind, input logic [63:0] id);
    logic [7:0] pp [0:7]  = '{8'h00, 8'hF1, 8'h00, 8'h00, 8'h00, 8'h01, 8'h43, 8'h00};
    logic [7:0] rp [0:18] = '{8'h00, 8'h00, 8'h01, 8'h10, 8'h04, 8'h01, 8'h00, 8'h0D,
                              8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h01, 8'h00, 8'h00,
                              8'h00, 8'h00, 8'h23};
    int l;
    logic [15:0] c;
    for (int i = 0; i < 41; i++) expFrame[i] = 8'h00;
    l = (kind == 1) ? 8'h12 : (kind == 2) ? 8'h14 : 8'h1D;
    expFrame[0] = 8'hB2; expFrame[1] = 8'h4D; expFrame[2] = 8'(l);
    expFrame[3] = (kind == 3) ? 8'h07 : 8'h01;
    for (int i = 0; i < 8; i++) expFrame[4 + i] = id[(7 - i) * 8 +: 8];
    if (kind == 3) for (int i = 0; i < 19; i++) expFrame[12 + i] = rp[i];
    else           for (int i = 0; i < 8; i++)  expFrame[12 + i] = pp[i];
    if (kind == 2) begin expFrame[20] = 8'h88; expFrame[21] = 8'hB4; end
    c = refCrc(l);
    expFrame[l + 2] = c[15:8];
    expFrame[l + 3] = c[7:0];
    expLen = l + 4;
  endtask

  task automatic sendFrame(input logic [7:0] l, input logic [7:0] cmd, input logic [7:0] req,
                           input logic good, output logic [31:0] expT);
    @(negedge clk);
    rxMem[2] = l; rxMem[3] = cmd; rxMem[6] = req;
    frameDone = 1'b1; crcOk = good;
    expT = tickNow + 32'd512;
    @(negedge clk);
    frameDone = 1'b0; crcOk = 1'b0;
  endtask

  task automatic waitStart(input int s0);
    for (int i = 0; i < 700 && startCnt == s0; i++) @(negedge clk);
  endtask

  task automatic checkBytes(input string tag);
    int bad = 0;
    for (int i = 0; i < expLen + 2; i++) begin
      @(negedge clk); txRdAddr = 8'(i); #1;
      if (txByte !== expFrame[i]) begin
        bad++;
        check(1'b0, $sformatf("%s byte %0d", tag, i), txByte, expFrame[i]);
      end
    end
    if (bad == 0) check(1'b1, tag, 0, 0);
  endtask

  task automatic finishTx();
    int c0;
    c0 = clrCnt;
    @(negedge clk); txDone = 1'b1;
    @(negedge clk); txDone = 1'b0;
    repeat (2) @(negedge clk);
    check(clrCnt == c0 + 1, "R9 clear after txDone", clrCnt, c0 + 1);
  endtask

  task automatic t_reset();
    check(txStart == 1'b0, "R10 txStart after reset", txStart, 0);
    check(rxClear == 1'b0, "R10 rxClear after reset", rxClear, 0);
    check(txLen == 8'h00, "R10 txLen after reset", txLen, 0);
  endtask

  task automatic t_reply(input int kind, input logic [7:0] l, input logic [7:0] cmd,
                         input logic [7:0] req, input logic [63:0] id, input string tag);
    logic [31:0] expT;
    int s0;
    cardId = id;
    buildExp(kind, id);
    s0 = startCnt;
    sendFrame(l, cmd, req, 1'b1, expT);
    waitStart(s0);
    check(startCnt == s0 + 1, {tag, " start pulse"}, startCnt, s0 + 1);
    check(lastStartTick == expT, "R6 start tick", lastStartTick, expT);
    check(txStartTime == expT, "R6 txStartTime", txStartTime, expT);
    check(txLen == 8'(expLen), {tag, " txLen"}, txLen, expLen);
    cardId = ~id;  // identifier already captured
    checkBytes({tag, "/R5 reply image"});
    finishTx();
  endtask

  task automatic t_reject(input logic [7:0] l, input logic [7:0] cmd, input logic [7:0] req,
                          input logic good, input string tag);
    logic [31:0] expT;
    int s0, c0;
    s0 = startCnt; c0 = clrCnt;
    sendFrame(l, cmd, req, good, expT);
    repeat (8) @(negedge clk);
    check(clrCnt == c0 + 1, {tag, " clear pulse"}, clrCnt, c0 + 1);
    repeat (600) @(negedge clk);
    check(startCnt == s0, {tag, " no start"}, startCnt, s0);
  endtask

  task automatic t_drop();
    logic [31:0] expT, junk;
    int s0;
    cardId = 64'h0102_0304_0506_0708;
    buildExp(1, cardId);
    s0 = startCnt;
    sendFrame(8'd6, 8'h00, 8'h00, 1'b1, expT);
    repeat (40) @(negedge clk);
    sendFrame(8'h10, 8'h06, 8'h00, 1'b1, junk);
    repeat (5) @(negedge clk);
    check(txStartTime == expT, "R8 time kept while pending", txStartTime, expT);
    check(txLen == 8'h16, "R8 length kept while pending", txLen, 8'h16);
    waitStart(s0);
    check(lastStartTick == expT, "R8 original start tick", lastStartTick, expT);
    sendFrame(8'd6, 8'h00, 8'h01, 1'b1, junk);
    repeat (3) @(negedge clk);
    checkBytes("R8 reply kept while sending");
    finishTx();
    repeat (700) @(negedge clk);
    check(startCnt == s0 + 1, "R8 single start", startCnt, s0 + 1);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) rxMem[i] = 8'h00;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_reply(1, 8'd6, 8'h00, 8'h00, 64'h0123_4567_89AB_CDEF, "R2 poll code 0");
    t_reply(2, 8'd6, 8'h00, 8'h01, 64'hFEDC_BA98_7654_3210, "R3 poll code 1");
    t_reply(3, 8'h10, 8'h06, 8'h00, 64'h1122_3344_5566_7788, "R4 read request");
    t_reply(3, 8'd6, 8'h06, 8'h01, 64'hA5A5_0000_FFFF_5A5A, "R4 read min length");
    t_reject(8'd6, 8'h00, 8'h00, 1'b0, "R1 bad crc");
    t_reject(8'd6, 8'h00, 8'h02, 1'b1, "R7 poll code 2");
    t_reject(8'd7, 8'h00, 8'h00, 1'b1, "R7 poll length 7");
    t_reject(8'd5, 8'h06, 8'h00, 1'b1, "R7 read length 5");
    t_reject(8'd6, 8'h05, 8'h00, 1'b1, "R7 other command");
    t_drop();
    t_reply(2, 8'd6, 8'h00, 8'h01, 64'h0F0F_F0F0_3C3C_C3C3, "R9 listening again");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule